// File: doc/BRIEF.md
# Torus Minimal Route Selector

This block makes the routing decision for one router node in a three-dimensional torus whose axes wrap around. The node knows its own X, Y and Z coordinates and the size of each axis, all given as runtime inputs. For every packet header offered on a valid/ready handshake, the block works out the shortest way round on each axis. It collects the output directions that bring the packet closer to its destination and picks one of them that is free, using a rotating priority.

A header whose destination equals the node's own coordinates goes to the local reception port, and no direction is chosen. A header can also carry a deposit flag. A deposit packet leaves a copy at every node it passes through, so it must travel along a single axis. A deposit header whose destination differs from the node on more than one axis is accepted and flagged as illegal. When no candidate direction is free, the block holds ready low and tries again on the next cycle. The decision appears on registered outputs one cycle after the header is accepted.

Top module: `torus_route_sel`

## Requirements
- R1: After reset, out_valid, out_port, out_local and out_illegal are all 0, and the rotating priority search starts at port index 0.
- R2: On each axis the offset is d = (destination - own) mod size, in the range 0..size-1. The plus direction is a candidate when d != 0 and 2d <= size. The minus direction is a candidate when 2d > size. An axis with d = 0 offers no candidate.
- R3: When the two ways round an axis are equally long (2d == size), only the plus direction is a candidate.
- R4: out_port is one-hot with bit 0 = X plus, bit 1 = X minus, bit 2 = Y plus, bit 3 = Y minus, bit 4 = Z plus, bit 5 = Z minus. It is zero when no direction is chosen.
- R5: A chosen direction is always both a candidate and marked free in port_free in the cycle the header is accepted.
- R6: The search for a free candidate starts at the index after the last granted direction and wraps from 5 to 0. Only cycles that grant a direction move the start point.
- R7: When a header needs a direction and no candidate is free, hdr_ready is 0 and no result is produced. The header is accepted in the first cycle that a candidate becomes free.
- R8: A header whose destination equals the node's coordinates is accepted whatever port_free holds. It yields out_local = 1 with out_port = 0.
- R9: A deposit header that differs from the node on exactly one axis yields out_local = 1 together with a chosen direction.
- R10: A deposit header that differs from the node on two or more axes is accepted at once. It yields out_illegal = 1, out_port = 0 and out_local = 0.
- R11: out_valid is 1 for exactly the one cycle that follows each accepted header and is 0 otherwise.
- R12: A deposit header whose destination equals the node yields out_local = 1 and out_port = 0, with out_illegal = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_x | input | 5 | Own X coordinate |
| my_y | input | 5 | Own Y coordinate |
| my_z | input | 6 | Own Z coordinate |
| size_x | input | 6 | Number of nodes on the X axis (1..32) |
| size_y | input | 6 | Number of nodes on the Y axis (1..32) |
| size_z | input | 7 | Number of nodes on the Z axis (1..64) |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be accepted this cycle |
| hdr_dst_x | input | 5 | Destination X |
| hdr_dst_y | input | 5 | Destination Y |
| hdr_dst_z | input | 6 | Destination Z |
| hdr_deposit | input | 1 | Deliver a copy at every hop |
| port_free | input | 6 | Availability flag per output direction |
| out_valid | output | 1 | Decision valid |
| out_port | output | 6 | One-hot chosen direction |
| out_local | output | 1 | Deliver to local reception |
| out_illegal | output | 1 | Deposit header not on a single axis |

## Verification
Random headers over random axis sizes, own coordinates and availability masks exercise the wraparound fold on both sides of the half-way point. Even sizes with the destination exactly half-way round pin down the tie rule, which would otherwise look like a correct minus choice. A sequence that frees every port while several candidates are open shows whether the rotating start point moves only on grants. Deposit headers on one axis, on two axes and at the destination separate legal copying, the illegal flag and plain local delivery. Masks that free only non-candidate ports force stalls and show that the header is held and then taken once a candidate opens.

// File: rtl/torus_route_pkg.sv
// Shared constants for the torus route selector.
// Assumes six directional ports, ordered X+, X-, Y+, Y-, Z+, Z-.
package torus_route_pkg;
    localparam int NUM_DIRS = 6;
    localparam int DIR_IDX_W = $clog2(NUM_DIRS);

    typedef enum logic [DIR_IDX_W-1:0] {
        DIR_XP = 3'd0,
        DIR_XM = 3'd1,
        DIR_YP = 3'd2,
        DIR_YM = 3'd3,
        DIR_ZP = 3'd4,
        DIR_ZM = 3'd5
    } dir_e;

    typedef struct packed {
        logic local_hit;
        logic illegal;
        logic [NUM_DIRS-1:0] cand;
    } route_info_t;
endpackage

// File: rtl/torus_axis_dist.sv
// Wraparound distance fold for one torus axis.
// Produces the productive direction(s) for this axis: plus when the
// forward offset is at most half the ring, minus when it is more.
// Assumes own and destination coordinates are below axis_size.
module torus_axis_dist #(
    parameter int COORD_W = 5
) (
    input  logic [COORD_W-1:0] own_c,
    input  logic [COORD_W-1:0] dst_c,
    input  logic [COORD_W:0]   axis_size,
    output logic               go_plus,
    output logic               go_minus,
    output logic               on_axis
);
    localparam int EXT_W = COORD_W + 2;

    logic [EXT_W-1:0] fwd;
    logic [EXT_W-1:0] twice;
    logic [EXT_W-1:0] size_ext;

    // Forward offset modulo the axis size.
    always_comb begin
        size_ext = EXT_W'(axis_size);
        if (dst_c >= own_c)
            fwd = EXT_W'(dst_c) - EXT_W'(own_c);
        else
            fwd = EXT_W'(dst_c) + size_ext - EXT_W'(own_c);
        twice = fwd << 1;
    end

    // Direction choice; ties resolve toward plus.
    always_comb begin
        on_axis  = (fwd != '0);
        go_plus  = on_axis && (twice <= size_ext);
        go_minus = on_axis && (twice > size_ext);
    end
endmodule

// File: rtl/torus_rr_pick.sv
// Rotating-priority pick among requesting ports.
// The search starts at the stored pointer and wraps; after each taken
// grant the pointer moves to the index after the granted one.
// Assumes req is already masked with availability.
module torus_rr_pick #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] grant,
    output logic         any_grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [PW-1:0] gidx;

    // Scan from the pointer and take the first requester.
    always_comb begin
        grant     = '0;
        gidx      = '0;
        any_grant = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr) + i) % N;
            if (!any_grant && req[idx]) begin
                any_grant  = 1'b1;
                grant[idx] = 1'b1;
                gidx       = PW'(idx);
            end
        end
    end

    // Advance the start point past the granted index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (take && any_grant)
            ptr <= (int'(gidx) == N - 1) ? '0 : gidx + PW'(1);
    end

    p_grant_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < N);
endmodule

// File: rtl/torus_route_sel.sv
// Routing decision stage of one torus router node.
// Folds the offset on each axis, builds the productive direction mask,
// picks a free direction in rotating order and registers the result
// one cycle after the header handshake. Stalls (ready low) when a
// direction is needed but none of the candidates is free.
// Assumes coordinates are below the matching axis size.
module torus_route_sel
    import torus_route_pkg::*;
#(
    parameter int XW = 5,
    parameter int YW = 5,
    parameter int ZW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XW-1:0]       my_x,
    input  logic [YW-1:0]       my_y,
    input  logic [ZW-1:0]       my_z,
    input  logic [XW:0]         size_x,
    input  logic [YW:0]         size_y,
    input  logic [ZW:0]         size_z,
    input  logic                hdr_valid,
    output logic                hdr_ready,
    input  logic [XW-1:0]       hdr_dst_x,
    input  logic [YW-1:0]       hdr_dst_y,
    input  logic [ZW-1:0]       hdr_dst_z,
    input  logic                hdr_deposit,
    input  logic [NUM_DIRS-1:0] port_free,
    output logic                out_valid,
    output logic [NUM_DIRS-1:0] out_port,
    output logic                out_local,
    output logic                out_illegal
);
    logic [2:0] ax_plus, ax_minus, ax_on;
    route_info_t info;
    logic [NUM_DIRS-1:0] avail;
    logic [NUM_DIRS-1:0] grant;
    logic any_grant;
    logic accept;
    logic needs_dir;

    torus_axis_dist #(.COORD_W(XW)) u_ax_x (
        .own_c(my_x), .dst_c(hdr_dst_x), .axis_size(size_x),
        .go_plus(ax_plus[0]), .go_minus(ax_minus[0]), .on_axis(ax_on[0]));
    torus_axis_dist #(.COORD_W(YW)) u_ax_y (
        .own_c(my_y), .dst_c(hdr_dst_y), .axis_size(size_y),
        .go_plus(ax_plus[1]), .go_minus(ax_minus[1]), .on_axis(ax_on[1]));
    torus_axis_dist #(.COORD_W(ZW)) u_ax_z (
        .own_c(my_z), .dst_c(hdr_dst_z), .axis_size(size_z),
        .go_plus(ax_plus[2]), .go_minus(ax_minus[2]), .on_axis(ax_on[2]));

    // Interleave per-axis directions into the port order.
    always_comb begin
        for (int a = 0; a < 3; a++) begin
            info.cand[2*a]   = ax_plus[a];
            info.cand[2*a+1] = ax_minus[a];
        end
        info.local_hit = (ax_on == 3'b000);
        info.illegal   = hdr_deposit && ($countones(ax_on) > 1);
    end

    // Candidates that are free may be granted; illegal headers take none.
    always_comb begin
        avail     = info.illegal ? '0 : (info.cand & port_free);
        needs_dir = !info.local_hit && !info.illegal;
        hdr_ready = rst_n && (!needs_dir || any_grant);
        accept    = hdr_valid && hdr_ready;
    end

    torus_rr_pick #(.N(NUM_DIRS)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(avail),
        .take(accept && needs_dir), .grant(grant), .any_grant(any_grant));

    // Register the decision one cycle after the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_port    <= '0;
            out_local   <= 1'b0;
            out_illegal <= 1'b0;
        end else if (accept) begin
            out_valid   <= 1'b1;
            out_port    <= needs_dir ? grant : '0;
            out_local   <= info.local_hit || (hdr_deposit && !info.illegal);
            out_illegal <= info.illegal;
        end else begin
            out_valid   <= 1'b0;
            out_port    <= '0;
            out_local   <= 1'b0;
            out_illegal <= 1'b0;
        end
    end

    p_port_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_port));
    p_accept_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> out_valid);
    p_no_accept_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && hdr_ready) |=> !out_valid);
    p_stall_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> !out_valid);
    p_grant_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && needs_dir) |=> ((out_port & $past(port_free)) != '0));
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_port == '0 && !out_local));
    p_local_noport_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && info.local_hit) |-> hdr_ready);
endmodule

// File: tb/torus_route_sel_tb_top.sv
module torus_route_sel_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] my_x = '0, my_y = '0;
    logic [5:0] my_z = '0;
    logic [5:0] size_x = 6'd8, size_y = 6'd8;
    logic [6:0] size_z = 7'd8;
    logic hdr_valid = 1'b0;
    logic hdr_ready;
    logic [4:0] hdr_dst_x = '0, hdr_dst_y = '0;
    logic [5:0] hdr_dst_z = '0;
    logic hdr_deposit = 1'b0;
    logic [5:0] port_free = '0;
    logic out_valid, out_local, out_illegal;
    logic [5:0] out_port;

    int n_tests = 0;
    int n_fail = 0;
    int bptr = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    torus_route_sel dut_i (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .my_z(my_z),
        .size_x(size_x), .size_y(size_y), .size_z(size_z),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y), .hdr_dst_z(hdr_dst_z),
        .hdr_deposit(hdr_deposit), .port_free(port_free),
        .out_valid(out_valid), .out_port(out_port),
        .out_local(out_local), .out_illegal(out_illegal));

    // {minus, plus} for one axis, from the fold rule.
    function automatic logic [1:0] axis_dir(int own, int dst, int sz);
        int d;
        d = ((dst - own) % sz + sz) % sz;
        if (d == 0) return 2'b00;
        if (2 * d <= sz) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [5:0] cand_mask();
        logic [1:0] ax, ay, az;
        ax = axis_dir(int'(my_x), int'(hdr_dst_x), int'(size_x));
        ay = axis_dir(int'(my_y), int'(hdr_dst_y), int'(size_y));
        az = axis_dir(int'(my_z), int'(hdr_dst_z), int'(size_z));
        return {az, ay, ax};
    endfunction

    function automatic int axes_used(logic [5:0] c);
        return int'(c[1:0] != 0) + int'(c[3:2] != 0) + int'(c[5:4] != 0);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Offer the current header; checks stall, grant and outputs.
    task automatic route(string req);
        logic [5:0] c, avail, eg;
        logic illegal, loc, needs;
        int gi;
        c = cand_mask();
        illegal = hdr_deposit && axes_used(c) > 1;
        loc = (c == 0);
        needs = !loc && !illegal;
        hdr_valid = 1'b1;
        #1;
        avail = c & port_free;
        if (needs && avail == 0) begin
            check("R7", "ready during stall", int'(hdr_ready), 0);
            @(negedge clk);
            check("R7", "no output while stalled", int'(out_valid), 0);
            port_free = 6'h3f;
            #1;
            avail = c;
        end
        check(req, "ready", int'(hdr_ready), 1);
        eg = '0;
        if (needs) begin
            for (int i = 0; i < 6; i++) begin
                gi = (bptr + i) % 6;
                if (avail[gi]) begin
                    eg[gi] = 1'b1;
                    bptr = (gi + 1) % 6;
                    break;
                end
            end
        end
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R11", "out_valid after accept", int'(out_valid), 1);
        check(req, "out_port", int'(out_port), int'(eg));
        check(req, "out_local", int'(out_local), int'(loc || (hdr_deposit && !illegal)));
        check(req, "out_illegal", int'(out_illegal), int'(illegal));
    endtask

    task automatic set_hdr(int x, int y, int z, logic dep, logic [5:0] fr);
        hdr_dst_x = 5'(x); hdr_dst_y = 5'(y); hdr_dst_z = 6'(z);
        hdr_deposit = dep; port_free = fr;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_port in reset", int'(out_port), 0);
        check("R1", "out_local in reset", int'(out_local), 0);
        check("R1", "out_illegal in reset", int'(out_illegal), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: X+ only, own at 0 on size 8.
        set_hdr(3, 0, 0, 1'b0, 6'h3f); route("R2");
        // Wrap: dst 6 on size 8 is 2 back, minus.
        set_hdr(6, 0, 0, 1'b0, 6'h3f); route("R2");
        // Tie on X and Z (4 of 8): plus only.
        set_hdr(4, 0, 4, 1'b0, 6'h3f); route("R3");
        check("R3", "tie never minus", int'(out_port[1] | out_port[5]), 0);
        // Idle cycle: no pulse.
        @(negedge clk);
        check("R11", "no pulse when idle", int'(out_valid), 0);
        // Local delivery with nothing free.
        set_hdr(0, 0, 0, 1'b0, 6'h00); route("R8");
        // Rotation: X+, Y+, Z+ all candidates, all free.
        set_hdr(1, 1, 1, 1'b0, 6'h3f); route("R6");
        set_hdr(1, 1, 1, 1'b0, 6'h3f); route("R6");
        set_hdr(1, 1, 1, 1'b0, 6'h3f); route("R6");
        // Stall: only non-candidate ports free.
        set_hdr(2, 0, 0, 1'b0, 6'h3e); route("R5");
        set_hdr(0, 7, 0, 1'b0, 6'b110111); route("R7");
        // Deposit on one axis, at destination, and across two axes.
        set_hdr(0, 0, 5, 1'b1, 6'h3f); route("R9");
        set_hdr(0, 0, 0, 1'b1, 6'h00); route("R12");
        set_hdr(2, 3, 0, 1'b1, 6'h00); route("R10");
        // Large axes.
        size_x = 6'd32; size_y = 6'd32; size_z = 7'd64;
        my_x = 5'd31; my_z = 6'd63;
        set_hdr(15, 0, 31, 1'b0, 6'h3f); route("R3");

        // Random headers over random sizes, positions and masks.
        for (int t = 0; t < 400; t++) begin
            size_x = 6'(1 + $urandom_range(0, 31));
            size_y = 6'(1 + $urandom_range(0, 31));
            size_z = 7'(1 + $urandom_range(0, 63));
            my_x = 5'($urandom_range(0, int'(size_x) - 1));
            my_y = 5'($urandom_range(0, int'(size_y) - 1));
            my_z = 6'($urandom_range(0, int'(size_z) - 1));
            set_hdr($urandom_range(0, int'(size_x) - 1),
                    $urandom_range(0, int'(size_y) - 1),
                    $urandom_range(0, int'(size_z) - 1),
                    ($urandom_range(0, 3) == 0), 6'($urandom()));
            route("R5");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule